// File: doc/BRIEF.md
# Round-Robin Channel Monitor with Limit Checking

This block runs the measurement loop of a system health monitor. While its start control is high it walks a fixed loop of eight channels: six supply voltages, then an on-die temperature, then a remote-diode temperature. For each channel it asks an external converter for a conversion and waits for the done strobe carrying an 8-bit result. The remote temperature is the mean of sixteen conversions. An optional signed offset is added to one of the two temperature channels, with saturation at the 8-bit signed range.

Each finished result is written into that channel's value register. It is then compared against the channel's high and low limits, and the channel's status bit is updated from that comparison. When the last channel of a loop completes, the block pulses an end-of-loop flag. With it come two event flags that tell whether any voltage channel, or any temperature channel, was out of limit during that loop.

Dropping the start control puts the block in standby at once. Any conversion still in flight is abandoned, while the value and status registers hold their contents.

Top module: `rr_monitor`

## Requirements
- R1: One cycle after start_i is sampled high, conv_req_o is high and the loop begins at channel 0. One cycle after start_i is sampled low, conv_req_o is low and standby_o is high, and values_o and status_o keep their contents.
- R2: Channels complete in the order 0,1,2,3,4,5,6,7 and then wrap to 0. conv_ch_o holds steady while a request is waiting for its done strobe.
- R3: Channel 7 takes sixteen conversions. Its raw result is the two's complement sum of the sixteen samples shifted right arithmetically by 4, which is floor(sum/16). Every other channel takes a single conversion.
- R4: The offset applies to channel 6 when offset_sel_i equals 3'b011, where bit 0 is the test-control bit, bit 1 is id bit 6 and bit 2 is id bit 7. For any other value of offset_sel_i it applies to channel 7. Voltage channels 0 to 5 are never offset.
- R5: The offset sum is signed and saturates: results above +127 give 8'h7F and results below -128 give 8'h80.
- R6: A result is out of limit when it is greater than the high limit, or less than or equal to the low limit. Channels 6 and 7 compare as two's complement numbers and channels 0 to 5 compare as unsigned numbers. Channel i uses the limit slice [8*i+7:8*i].
- R7: Each completed channel produces a one-cycle val_we_o pulse with val_ch_o. In the same cycle, the channel's value register holds the offset-adjusted result and its status bit is 1 when out of limit and 0 otherwise. status_o changes in no other cycle.
- R8: After reset, values_o, status_o and diode_flag_o are all zero, conv_req_o is low, and no flag is pulsing.
- R9: If start_i is low in the cycle a done strobe arrives, or at any point in the middle of a loop, the pending conversion is abandoned and no value or status write follows. The next start begins at channel 0 with a fresh average.
- R10: A done strobe that arrives while the block is idle writes nothing.
- R11: diode_flag_o is updated when channel 7 completes. It becomes the OR of diode_fault_i over the sixteen samples of that measurement.
- R12: cycle_done_o pulses in the same cycle as the channel 7 write. In that cycle, volt_evt_o is the OR of the status results of channels 0 to 5 from this loop, and temp_evt_o is the OR for channels 6 and 7. Neither event flag is high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loop enable; low means standby |
| offset_i | input | 8 | Two's complement temperature offset |
| offset_sel_i | input | 3 | Offset routing bits (see R4) |
| hi_lim_i | input | 64 | High limits, 8 bits per channel |
| lo_lim_i | input | 64 | Low limits, 8 bits per channel |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 8 | Converter result, valid with done |
| diode_fault_i | input | 1 | Remote diode fault, valid with done |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | 3 | Channel being converted |
| standby_o | output | 1 | Loop stopped |
| val_we_o | output | 1 | Value register written this cycle |
| val_ch_o | output | 3 | Channel of the last write |
| values_o | output | 64 | Value registers, 8 bits per channel |
| status_o | output | 8 | Out-of-limit status per channel |
| diode_flag_o | output | 1 | Remote diode fault status |
| cycle_done_o | output | 1 | Loop completed this cycle |
| volt_evt_o | output | 1 | A voltage channel was out of limit this loop |
| temp_evt_o | output | 1 | A temperature channel was out of limit this loop |

## Verification
The case where two functions collide is the stop request landing in the same cycle as a done strobe. The converter model in the bench lowers start_i on exactly the cycle it presents done. This is done once for a single-conversion voltage channel, once at the sixth sample of the remote average, and once at its sixteenth and final sample. In each of these cases the bench expects no write in the following cycle and a request line that is already low. After the restart it expects channel 0 to come first, and the remote-channel mean to be built only from new samples.

// File: rtl/rr_mon_pkg.sv
package rr_mon_pkg;
  typedef enum logic {ST_IDLE, ST_CONV} seq_st_e;
  localparam logic [2:0] SEL_TO_INT = 3'b011;
endpackage

// File: rtl/rr_seq.sv
module rr_seq
  import rr_mon_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DW      = 8,
  parameter int AVG_LG2 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       conv_done_i,
  input  logic [DW-1:0]              conv_data_i,
  input  logic                       fault_i,
  output logic                       conv_req_o,
  output logic [$clog2(NUM_CH)-1:0]  ch_o,
  output logic                       fin_o,
  output logic [DW-1:0]              res_o,
  output logic                       fault_o
);
  localparam int CW = $clog2(NUM_CH);
  localparam int AW = DW + AVG_LG2;
  localparam logic [CW-1:0] EXT = CW'(NUM_CH - 1);

  seq_st_e               st_q;
  logic [CW-1:0]         ch_q;
  logic [AVG_LG2-1:0]    cnt_q;
  logic signed [AW-1:0]  acc_q;
  logic signed [AW-1:0]  sum_w;
  logic                  flt_q;
  logic                  is_ext, take, last_smp;

  assign is_ext   = (ch_q == EXT);
  assign take     = (st_q == ST_CONV) && conv_done_i && start_i;
  assign last_smp = !is_ext || (&cnt_q);
  assign sum_w    = acc_q + {{AVG_LG2{conv_data_i[DW-1]}}, conv_data_i};

  assign fin_o      = take && last_smp;
  // arithmetic shift of the running sum gives floor of the mean
  assign res_o      = is_ext ? sum_w[AW-1:AVG_LG2] : conv_data_i;
  assign fault_o    = flt_q | fault_i;
  assign conv_req_o = (st_q == ST_CONV);
  assign ch_o       = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      flt_q <= 1'b0;
    end else if (!start_i) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      flt_q <= 1'b0;
    end else begin
      st_q <= ST_CONV;
      if (take) begin
        if (!last_smp) begin
          cnt_q <= cnt_q + AVG_LG2'(1);
          acc_q <= sum_w;
          flt_q <= flt_q | fault_i;
        end else begin
          cnt_q <= '0;
          acc_q <= '0;
          flt_q <= 1'b0;
          ch_q  <= is_ext ? '0 : ch_q + CW'(1);
        end
      end
    end
  end

  // R1
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !conv_req_o);
  // R1
  start_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> conv_req_o);
  // R2
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i && start_i) |=> $stable(ch_o));
  // R3
  single_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_o != EXT) |-> (cnt_q == '0));
endmodule

// File: rtl/rr_offset.sv
module rr_offset
  import rr_mon_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CW     = 3,
  parameter int INT_CH = 6,
  parameter int EXT_CH = 7
) (
  input  logic [CW-1:0] ch_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] off_i,
  input  logic [2:0]    sel_i,
  output logic [DW-1:0] data_o
);
  logic [CW-1:0] tgt;
  logic [DW:0]   sum;
  logic [DW-1:0] sat;

  assign tgt = (sel_i == SEL_TO_INT) ? CW'(INT_CH) : CW'(EXT_CH);
  assign sum = {data_i[DW-1], data_i} + {off_i[DW-1], off_i};

  always_comb begin
    if (sum[DW] != sum[DW-1]) sat = {sum[DW], {(DW-1){~sum[DW]}}};
    else                      sat = sum[DW-1:0];
  end

  assign data_o = (ch_i == tgt) ? sat : data_i;
endmodule

// File: rtl/rr_limit.sv
module rr_limit #(
  parameter int NUM_CH = 8,
  parameter int DW     = 8,
  parameter int CW     = 3,
  parameter int INT_CH = 6,
  parameter int EXT_CH = 7
) (
  input  logic [CW-1:0]        ch_i,
  input  logic [DW-1:0]        val_i,
  input  logic [NUM_CH*DW-1:0] hi_i,
  input  logic [NUM_CH*DW-1:0] lo_i,
  output logic                 oor_o,
  output logic                 temp_o
);
  logic [DW-1:0] hi, lo;

  assign hi     = hi_i[int'(ch_i)*DW +: DW];
  assign lo     = lo_i[int'(ch_i)*DW +: DW];
  assign temp_o = (ch_i == CW'(INT_CH)) || (ch_i == CW'(EXT_CH));

  always_comb begin
    if (temp_o) oor_o = ($signed(val_i) > $signed(hi)) || ($signed(val_i) <= $signed(lo));
    else        oor_o = (val_i > hi) || (val_i <= lo);
  end
endmodule

// File: rtl/rr_monitor.sv
module rr_monitor #(
  parameter int NUM_CH  = 8,
  parameter int DW      = 8,
  parameter int AVG_LG2 = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [DW-1:0]              offset_i,
  input  logic [2:0]                 offset_sel_i,
  input  logic [NUM_CH*DW-1:0]       hi_lim_i,
  input  logic [NUM_CH*DW-1:0]       lo_lim_i,
  input  logic                       conv_done_i,
  input  logic [DW-1:0]              conv_data_i,
  input  logic                       diode_fault_i,
  output logic                       conv_req_o,
  output logic [$clog2(NUM_CH)-1:0]  conv_ch_o,
  output logic                       standby_o,
  output logic                       val_we_o,
  output logic [$clog2(NUM_CH)-1:0]  val_ch_o,
  output logic [NUM_CH*DW-1:0]       values_o,
  output logic [NUM_CH-1:0]          status_o,
  output logic                       diode_flag_o,
  output logic                       cycle_done_o,
  output logic                       volt_evt_o,
  output logic                       temp_evt_o
);
  localparam int CW     = $clog2(NUM_CH);
  localparam int INT_CH = NUM_CH - 2;
  localparam int EXT_CH = NUM_CH - 1;
  localparam logic [CW-1:0] EXT = CW'(EXT_CH);

  logic [CW-1:0] ch_w;
  logic          fin_w, fault_w, oor_w, temp_w;
  logic [DW-1:0] raw_w, adj_w;
  logic [DW-1:0] val_q [NUM_CH];
  logic          ev_v_q, ev_t_q;

  rr_seq #(.NUM_CH(NUM_CH), .DW(DW), .AVG_LG2(AVG_LG2)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .fault_i     (diode_fault_i),
    .conv_req_o  (conv_req_o),
    .ch_o        (ch_w),
    .fin_o       (fin_w),
    .res_o       (raw_w),
    .fault_o     (fault_w)
  );

  rr_offset #(.DW(DW), .CW(CW), .INT_CH(INT_CH), .EXT_CH(EXT_CH)) u_off (
    .ch_i   (ch_w),
    .data_i (raw_w),
    .off_i  (offset_i),
    .sel_i  (offset_sel_i),
    .data_o (adj_w)
  );

  rr_limit #(.NUM_CH(NUM_CH), .DW(DW), .CW(CW), .INT_CH(INT_CH), .EXT_CH(EXT_CH)) u_lim (
    .ch_i   (ch_w),
    .val_i  (adj_w),
    .hi_i   (hi_lim_i),
    .lo_i   (lo_lim_i),
    .oor_o  (oor_w),
    .temp_o (temp_w)
  );

  assign conv_ch_o = ch_w;
  assign standby_o = !conv_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) val_q[i] <= '0;
      status_o <= '0;
    end else if (fin_w) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_w == CW'(i)) begin
          val_q[i]    <= adj_w;
          status_o[i] <= oor_w;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_val
    assign values_o[g*DW +: DW] = val_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_we_o     <= 1'b0;
      val_ch_o     <= '0;
      diode_flag_o <= 1'b0;
      cycle_done_o <= 1'b0;
      volt_evt_o   <= 1'b0;
      temp_evt_o   <= 1'b0;
      ev_v_q       <= 1'b0;
      ev_t_q       <= 1'b0;
    end else begin
      val_we_o     <= fin_w;
      cycle_done_o <= 1'b0;
      volt_evt_o   <= 1'b0;
      temp_evt_o   <= 1'b0;
      if (!start_i) begin
        ev_v_q <= 1'b0;
        ev_t_q <= 1'b0;
      end else if (fin_w) begin
        val_ch_o <= ch_w;
        if (ch_w == EXT) begin
          diode_flag_o <= fault_w;
          cycle_done_o <= 1'b1;
          volt_evt_o   <= ev_v_q;
          temp_evt_o   <= ev_t_q | oor_w;
          ev_v_q       <= 1'b0;
          ev_t_q       <= 1'b0;
        end else if (temp_w) begin
          ev_t_q <= ev_t_q | oor_w;
        end else begin
          ev_v_q <= ev_v_q | oor_w;
        end
      end
    end
  end

  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !val_we_o |-> $stable(status_o));
  // R9
  we_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_we_o |-> $past(start_i));
  // R10
  we_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_we_o |-> $past(conv_req_o));
  // R12
  evt_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_evt_o || temp_evt_o) |-> cycle_done_o);
  // R12
  end_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_o |-> (val_we_o && (val_ch_o == EXT)));
endmodule

// File: tb/sim_rr_monitor.sv
module sim_rr_monitor;
  localparam int NC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        start;
  logic [7:0]  offset;
  logic [2:0]  osel;
  logic [63:0] hi, lo;
  logic        done;
  logic [7:0]  data;
  logic        fault;

  logic        conv_req, standby, val_we, diode_flag, cycle_done, volt_evt, temp_evt;
  logic [2:0]  conv_ch, val_ch;
  logic [63:0] values;
  logic [7:0]  status;

  rr_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .offset_i(offset),
    .offset_sel_i(osel), .hi_lim_i(hi), .lo_lim_i(lo), .conv_done_i(done),
    .conv_data_i(data), .diode_fault_i(fault), .conv_req_o(conv_req),
    .conv_ch_o(conv_ch), .standby_o(standby), .val_we_o(val_we), .val_ch_o(val_ch),
    .values_o(values), .status_o(status), .diode_flag_o(diode_flag),
    .cycle_done_o(cycle_done), .volt_evt_o(volt_evt), .temp_evt_o(temp_evt)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus owned by the main process
  bit start_cmd = 0, fault_mode = 0;
  int pat = 0, bsel = 0, cval = 0;
  int poke_req = 0, kill_gen = 0, kill_ch = 0, kill_at = 0;

  function automatic int s8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic bit oor_f(input int c, input int v);
    int h, l;
    h = int'(hi[c*8 +: 8]);
    l = int'(lo[c*8 +: 8]);
    if (c >= NC - 2) return (s8(v) > s8(h)) || (s8(v) <= s8(l));
    return (v > h) || (v <= l);
  endfunction

  // converter model and scoreboard, all on the falling edge
  logic [15:0] lfsr = 16'hACE1;
  int  dly = 0, smp = 0, sum = 0, exp_ch = 0, poke_seen = 0, kill_seen = 0;
  bit  fsum = 0, cv = 0, ct = 0;
  int  exp_val [NC];
  bit  exp_st [NC];
  bit  exp_flt = 0;
  bit  pend_we = 0, pend_cyc = 0, pend_kill = 0, ecv = 0, ect = 0;
  int  pch = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      start = 0; done = 0; data = 8'h00; fault = 0;
      smp = 0; sum = 0; fsum = 0; exp_ch = 0; cv = 0; ct = 0; dly = 0;
      for (int i = 0; i < NC; i++) begin exp_val[i] = 0; exp_st[i] = 0; end
    end else begin
      // R7 R10: a write appears exactly when a completion was issued
      chk(val_we == pend_we, pend_we ? "R7" : "R10", int'(val_we), int'(pend_we));
      if (pend_we) begin
        chk(int'(val_ch) == pch, "R2", int'(val_ch), pch);
        chk(int'(values[pch*8 +: 8]) == exp_val[pch],
            (pch == NC-1) ? "R3" : ((pch == NC-2) ? "R4" : "R7"),
            int'(values[pch*8 +: 8]), exp_val[pch]);
        chk(status[pch] == exp_st[pch], "R6", int'(status[pch]), int'(exp_st[pch]));
        if (pch == NC-1) chk(diode_flag == exp_flt, "R11", int'(diode_flag), int'(exp_flt));
      end
      chk(cycle_done == pend_cyc, "R12", int'(cycle_done), int'(pend_cyc));
      if (pend_cyc) chk(volt_evt == ecv && temp_evt == ect, "R12",
                        int'({volt_evt, temp_evt}), int'({ecv, ect}));
      if (pend_kill) chk(!val_we && !conv_req, "R9", int'({val_we, conv_req}), 0);
      pend_we = 0; pend_cyc = 0; pend_kill = 0;

      start = start_cmd;
      if (!start) begin
        smp = 0; sum = 0; fsum = 0; exp_ch = 0; cv = 0; ct = 0; dly = 0;
      end
      if (done) begin
        done = 0; fault = 0;
      end else if (poke_req != poke_seen) begin
        if (!conv_req) begin
          poke_seen = poke_req; done = 1; data = 8'h5A;
        end
      end else if (conv_req && start) begin
        if (dly > 0) dly--;
        else begin
          int c, v, r;
          bit fl, fin;
          c = int'(conv_ch);
          chk(c == exp_ch, "R2", c, exp_ch);
          case (pat)
            0: case (bsel)
                 0: v = int'(hi[c*8 +: 8]);
                 1: v = (int'(hi[c*8 +: 8]) + 1) & 255;
                 2: v = int'(lo[c*8 +: 8]);
                 default: v = (int'(lo[c*8 +: 8]) + 1) & 255;
               endcase
            1: v = int'(lfsr[7:0]);
            default: v = cval;
          endcase
          fl = (c == NC-1) && fault_mode && (smp == 3);
          data = 8'(v); fault = fl; done = 1;
          dly = int'(lfsr[9:8]) % 3;
          if (kill_gen != kill_seen && c == kill_ch && smp == kill_at) begin
            // R9: stop lands on the same edge as this done
            kill_seen = kill_gen; start = 0; pend_kill = 1;
            smp = 0; sum = 0; fsum = 0; exp_ch = 0; cv = 0; ct = 0;
          end else begin
            fin = 1;
            r = v;
            if (c == NC-1) begin
              sum += s8(v); fsum |= fl; smp++;
              if (smp < 16) fin = 0;
              else r = sum >>> 4;
            end else if (c == NC-2) r = s8(v);
            if (fin) begin
              int tgt;
              tgt = (osel == 3'b011) ? NC-2 : NC-1;
              if (c == tgt) r = sat8(r + s8(int'(offset)));
              exp_val[c] = r & 255;
              exp_st[c]  = oor_f(c, r & 255);
              if (c == NC-1) exp_flt = fsum;
              if (c >= NC-2) ct |= exp_st[c]; else cv |= exp_st[c];
              pend_we = 1; pch = c;
              if (c == NC-1) begin
                pend_cyc = 1; ecv = cv; ect = ct; cv = 0; ct = 0;
                smp = 0; sum = 0; fsum = 0;
              end
              exp_ch = (c + 1) % NC;
            end
          end
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  task automatic drive_slot();
    @(posedge clk); #1;
  endtask

  task automatic wait_loops(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!cycle_done) @(negedge clk);
    end
  endtask

  initial begin
    logic [63:0] snap;
    rst_n = 0; offset = 8'h00; osel = 3'b000;
    for (int i = 0; i < NC - 2; i++) begin
      hi[i*8 +: 8] = 8'(8'hC0 + i);
      lo[i*8 +: 8] = 8'(8'h40 + i);
    end
    hi[6*8 +: 8] = 8'd50;  lo[6*8 +: 8] = 8'hF6;
    hi[7*8 +: 8] = 8'd70;  lo[7*8 +: 8] = 8'hEC;
    repeat (3) @(negedge clk);
    // R8
    chk(values == 64'h0 && status == 8'h0 && !diode_flag, "R8", int'(status), 0);
    chk(!conv_req && standby && !cycle_done && !val_we, "R8", int'(conv_req), 0);
    drive_slot(); rst_n = 1;

    // R10: done while idle
    poke_req++;
    repeat (5) @(negedge clk);
    chk(values == 64'h0 && status == 8'h0, "R10", int'(values[7:0]), 0);

    // R6: limit boundaries on every channel, no offset
    pat = 0; bsel = 0;
    drive_slot(); start_cmd = 1;
    @(negedge clk); @(negedge clk);
    chk(conv_req && conv_ch == 3'd0, "R1", int'(conv_ch), 0);
    wait_loops(1);
    for (int b = 1; b < 4; b++) begin
      drive_slot(); bsel = b;
      wait_loops(2);
    end

    // R4 R5: saturation in both directions and routing
    pat = 2;
    drive_slot(); cval = 100; offset = 8'd100; osel = 3'b000;
    wait_loops(2);
    chk(values[63:56] == 8'h7F, "R5", int'(values[63:56]), 127);
    chk(values[55:48] == 8'd100, "R4", int'(values[55:48]), 100);
    drive_slot(); cval = 8'h9C; offset = 8'h9C; osel = 3'b011;
    wait_loops(2);
    chk(values[55:48] == 8'h80, "R5", int'(values[55:48]), 128);
    chk(values[63:56] == 8'h9C, "R4", int'(values[63:56]), 156);
    chk(values[7:0] == 8'h9C, "R4", int'(values[7:0]), 156);

    // random data across offset values and routing codes
    pat = 1;
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        drive_slot();
        osel   = (s == 0) ? 3'b000 : (s == 1) ? 3'b011 : (s == 2) ? 3'b111 : 3'b001;
        offset = (o == 0) ? 8'd5 : (o == 1) ? 8'hFD : (o == 2) ? 8'd100 : 8'h9C;
        wait_loops(2);
      end
    end

    // R11: fault seen in one sample, then cleared
    drive_slot(); fault_mode = 1;
    wait_loops(2);
    chk(diode_flag == 1'b1, "R11", int'(diode_flag), 1);
    drive_slot(); fault_mode = 0;
    wait_loops(2);
    chk(diode_flag == 1'b0, "R11", int'(diode_flag), 0);

    // R9: stop coinciding with done, single and averaged channels
    drive_slot(); kill_ch = 3; kill_at = 0; kill_gen++;
    wait_loops(2);
    drive_slot(); kill_ch = 7; kill_at = 5; kill_gen++;
    wait_loops(2);
    drive_slot(); kill_ch = 7; kill_at = 15; kill_gen++;
    wait_loops(2);

    // R1: stop holds registers
    drive_slot(); start_cmd = 0;
    repeat (3) @(negedge clk);
    snap = values;
    chk(!conv_req && standby, "R1", int'(conv_req), 0);
    repeat (20) @(negedge clk);
    chk(values == snap, "R1", int'(values[63:56]), int'(snap[63:56]));
    drive_slot(); start_cmd = 1;
    @(negedge clk); @(negedge clk);
    chk(conv_req && conv_ch == 3'd0, "R1", int'(conv_ch), 0);
    wait_loops(1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule